// File: doc/BRIEF.md
# Periodic Interrupt Output Selector

This block turns the periodic events of a clock/calendar counter chain into one active-low, open-drain style output. Four single-cycle event strobes come in: the 64 Hz tick and the carries out of the seconds, minutes and hours counters. A four-bit control nibble, written by the host, sets three things. It picks which of the four events drives the output. It picks whether the output gives a latched interrupt level or a short fixed-width pulse. It can also mask the output.

In interrupt mode the output pulls low on the selected event and stays low until the host writes a 0 to the interrupt flag. In pulse mode the output pulls low for a fixed time, 1/128 s expressed as a count of clock cycles, on each selected event and then floats again. The open-drain pin is modelled as a pull-enable: 1 means the pin is driven low and 0 means it floats. The block has no chip-select input. The output therefore keeps running whether the host bus is selected or in standby. The flag can be read back at any time.

Top module: `periodic_out_sel`

## Requirements
- R1: After a synchronous reset, `pin_pull_low` is 0 and `flag_rd` is 0. The control nibble is 4'b0000, which means 64 Hz source, pulse mode and unmasked.
- R2: Control bits [3:2] select the event: 0 = `period_evt[0]` (64 Hz), 1 = `period_evt[1]` (second), 2 = `period_evt[2]` (minute), 3 = `period_evt[3]` (hour). Strobes on the other three bits have no effect on the flag, the pulse or the pin.
- R3: A cycle with `ctl_wr` high loads `ctl_wdata` into the control nibble. Mode and mask take effect on the pin at the same clock edge as the write. The source selection applies to events from the next cycle on, so an event in the write cycle is judged against the old selection.
- R4: A selected event sets the flag in either mode, and `flag_rd` reads 1 from the clock edge that samples the event.
- R5: A cycle with `ack_wr` high and `ack_wdata` = 0 clears the flag. Writing 1 leaves it unchanged. A selected event in the same cycle as a clear wins, and the flag stays 1.
- R6: With control bit 1 = 1 (interrupt mode) and the pin unmasked, `pin_pull_low` equals the flag on every cycle.
- R7: With control bit 1 = 0 (pulse mode) and the pin unmasked, each selected event drives `pin_pull_low` to 1 for exactly `PULSE_CLKS` cycles, starting at the edge that samples the event. An event during a pulse restarts the full width.
- R8: While control bit 0 = 1 the pin floats (`pin_pull_low` = 0). The flag and the pulse timer keep running underneath, so clearing the mask brings back the pin state they give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_evt | input | 4 | Single-cycle event strobes: bit 0 64 Hz, bit 1 second, bit 2 minute, bit 3 hour |
| ctl_wr | input | 1 | Control nibble write strobe |
| ctl_wdata | input | 4 | Control nibble: [3:2] source, [1] interrupt mode, [0] mask |
| ack_wr | input | 1 | Flag write strobe |
| ack_wdata | input | 1 | Flag write data; 0 clears the flag |
| pin_pull_low | output | 1 | Open-drain enable; 1 pulls the pin low |
| flag_rd | output | 1 | Interrupt flag readback |

## Verification
The bench builds the block with `PULSE_CLKS` = 6. With that value a whole pulse, a restart in the middle of a pulse and the release that follows it fit into a handful of cycles and can be counted exactly. The same short width lets a long random run of events, control writes and flag writes produce many overlapping pulses and switches between modes. A behavioural model in the bench predicts the pin and the flag on every clock.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);
  localparam int unsigned CFG_W   = SEL_W + 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_64HZ = 2'd0,
    SRC_SEC  = 2'd1,
    SRC_MIN  = 2'd2,
    SRC_HOUR = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic irq_mode;
    logic mask;
  } pfo_cfg_t;
endpackage

// File: rtl/pfo_cfg_reg.sv
module pfo_cfg_reg
  import pfo_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output pfo_cfg_t         cfg_d,
  output pfo_cfg_t         cfg_q
);
  always_comb begin
    if (wr_en) cfg_d = pfo_cfg_t'(wdata);
    else       cfg_d = cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  assert_cfg_load_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg_q == pfo_cfg_t'($past(wdata))));
endmodule

// File: rtl/pfo_src_pick.sv
module pfo_src_pick #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] evt,
  input  logic [SW-1:0]   sel,
  output logic            hit
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign gated[i] = (sel == SW'(i)) & evt[i];
  end

  assign hit = |gated;
endmodule

// File: rtl/pfo_flag.sv
module pfo_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag_d,
  output logic flag_q
);
  always_comb begin
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag_q);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit) |=> $stable(flag_q));
endmodule

// File: rtl/pfo_pulse_timer.sv
module pfo_pulse_timer #(
  parameter int unsigned PULSE_CLKS = 256,
  localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic active_d,
  output logic active_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (hit)               cnt_d = CNT_W'(PULSE_CLKS);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign active_d = (cnt_d != '0);
  assign active_q = (cnt_q != '0);

  assert_timer_load_R7: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == CNT_W'(PULSE_CLKS)));
  assert_timer_count_R7: assert property (@(posedge clk) disable iff (rst)
    (!hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(PULSE_CLKS));
endmodule

// File: rtl/periodic_out_sel.sv
module periodic_out_sel
  import pfo_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] period_evt,
  input  logic               ctl_wr,
  input  logic [CFG_W-1:0]   ctl_wdata,
  input  logic               ack_wr,
  input  logic               ack_wdata,
  output logic               pin_pull_low,
  output logic               flag_rd
);
  pfo_cfg_t cfg_d, cfg_q;
  logic     hit;
  logic     flag_d, flag_q;
  logic     pulse_d, pulse_q;
  logic     pin_d, pin_q;

  pfo_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ctl_wr),
    .wdata (ctl_wdata),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  pfo_src_pick #(.NSRC(NUM_SRC)) u_pick (
    .evt (period_evt),
    .sel (cfg_q.src),
    .hit (hit)
  );

  pfo_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .clr    (ack_wr && !ack_wdata),
    .flag_d (flag_d),
    .flag_q (flag_q)
  );

  pfo_pulse_timer #(.PULSE_CLKS(PULSE_CLKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .active_d (pulse_d),
    .active_q (pulse_q)
  );

  always_comb begin
    if (cfg_d.mask)          pin_d = 1'b0;
    else if (cfg_d.irq_mode) pin_d = flag_d;
    else                     pin_d = pulse_d;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  assign pin_pull_low = pin_q;
  assign flag_rd      = flag_q;

  assert_mask_float_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q.mask |-> !pin_q);
  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.mask && cfg_q.irq_mode) |-> (pin_q == flag_q));
  assert_pulse_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.mask && !cfg_q.irq_mode) |-> (pin_q == pulse_q));
endmodule

// File: tb/periodic_out_sel_test.sv
`timescale 1ns/1ps
module periodic_out_sel_test;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] period_evt = '0;
  logic       ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       ack_wr = 1'b0;
  logic       ack_wdata = 1'b0;
  logic       pin_pull_low, flag_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_cfg = 0, m_flag = 0, m_cnt = 0, m_pin = 0;

  always #2 clk = ~clk;

  periodic_out_sel #(.PULSE_CLKS(P)) uut (
    .clk(clk), .rst(rst), .period_evt(period_evt),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ack_wr(ack_wr), .ack_wdata(ack_wdata),
    .pin_pull_low(pin_pull_low), .flag_rd(flag_rd)
  );

  always @(posedge clk) begin
    int hit, n_cfg, n_flag, n_cnt;
    if (rst) begin
      m_cfg = 0; m_flag = 0; m_cnt = 0; m_pin = 0;
    end else begin
      hit    = period_evt[(m_cfg >> 2) & 3];
      n_cfg  = ctl_wr ? int'(ctl_wdata) : m_cfg;
      n_flag = hit ? 1 : ((ack_wr && !ack_wdata) ? 0 : m_flag);
      n_cnt  = hit ? P : ((m_cnt > 0) ? m_cnt - 1 : 0);
      if (n_cfg & 1)      m_pin = 0;
      else if (n_cfg & 2) m_pin = n_flag;
      else                m_pin = (n_cnt != 0) ? 1 : 0;
      m_cfg = n_cfg; m_flag = n_flag; m_cnt = n_cnt;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (m_cfg & 1)      check("R8 pin vs model", int'(pin_pull_low), m_pin);
      else if (m_cfg & 2) check("R6 pin vs model", int'(pin_pull_low), m_pin);
      else                check("R7 pin vs model", int'(pin_pull_low), m_pin);
      check("R4 R5 flag vs model", int'(flag_rd), m_flag);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_cfg(logic [3:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
  endtask

  task automatic wr_ack(logic v);
    ack_wr = 1'b1; ack_wdata = v; tick(); ack_wr = 1'b0;
  endtask

  task automatic fire(logic [3:0] e);
    period_evt = e; tick(); period_evt = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 reset pin", int'(pin_pull_low), 0);
    check("R1 reset flag", int'(flag_rd), 0);

    // default config: 64 Hz, pulse mode
    fire(4'b0001);
    w = 0;
    for (int i = 0; i < 20; i++) begin
      if (pin_pull_low) w++;
      tick();
    end
    check("R7 pulse width", w, P);
    check("R4 flag set in pulse mode", int'(flag_rd), 1);

    // unselected source has no effect
    wr_ack(1'b0);
    fire(4'b1110);
    check("R2 unselected pin", int'(pin_pull_low), 0);
    check("R2 unselected flag", int'(flag_rd), 0);

    // seconds source, retrigger in the middle of a pulse
    wr_cfg(4'b0100);
    fire(4'b0010);
    w = 0;
    for (int i = 0; i < 30; i++) begin
      if (pin_pull_low) w++;
      if (i == 2) period_evt = 4'b0010;
      tick();
      period_evt = '0;
    end
    check("R7 retrigger width", w, 3 + P);

    // minute source, interrupt mode
    wr_ack(1'b0);
    check("R5 clear", int'(flag_rd), 0);
    wr_cfg(4'b1010);
    check("R6 idle pin", int'(pin_pull_low), 0);
    fire(4'b0100);
    check("R6 pin on event", int'(pin_pull_low), 1);
    repeat (10) tick();
    check("R6 pin held", int'(pin_pull_low), 1);
    wr_ack(1'b1);
    check("R5 write one keeps flag", int'(flag_rd), 1);
    period_evt = 4'b0100;
    wr_ack(1'b0);
    period_evt = '0;
    check("R5 event beats clear", int'(flag_rd), 1);
    wr_ack(1'b0);
    check("R5 flag cleared", int'(flag_rd), 0);
    check("R6 pin released", int'(pin_pull_low), 0);

    // mask while interrupt pending
    fire(4'b0100);
    wr_cfg(4'b1011);
    check("R8 masked pin", int'(pin_pull_low), 0);
    check("R8 flag kept under mask", int'(flag_rd), 1);
    wr_cfg(4'b1010);
    check("R8 unmask restores pin", int'(pin_pull_low), 1);
    wr_ack(1'b0);

    // hour source; event during write uses old selection
    wr_cfg(4'b1110);
    fire(4'b0111);
    check("R2 hour ignores others", int'(flag_rd), 0);
    period_evt = 4'b1000;
    wr_cfg(4'b0010);
    period_evt = '0;
    check("R3 old selection in write cycle", int'(flag_rd), 1);
    wr_ack(1'b0);
    fire(4'b1000);
    check("R3 new selection after write", int'(flag_rd), 0);

    // random traffic, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 4; b++) period_evt[b] = ($urandom_range(15) == 0);
      ctl_wr    = ($urandom_range(49) == 0);
      ctl_wdata = 4'($urandom_range(15));
      ack_wr    = ($urandom_range(19) == 0);
      ack_wdata = 1'($urandom_range(1));
      tick();
    end
    period_evt = '0; ctl_wr = 1'b0; ack_wr = 1'b0;
    repeat (2) tick();
    finish_run();
  end
endmodule